// File: doc/BRIEF.md
# Sequential Vector Convolution Engine

This block computes the full linear convolution of two signed integer vectors, A of length m and B of length n. It forms every output term with a single multiply-accumulate unit. The vectors are first written one element at a time into two internal register stores. A one-cycle start pulse then launches the computation, with the two lengths sampled at that moment. The result has m+n−1 terms. They are streamed out through a valid/ready handshake, one term per accepted transfer, and the final term is marked with a last flag.

Ordering follows a highest-index-first convention. An input vector is listed as [a_m … a_1], and the output appears in the same sense, as c_{m+n−1} first and c_1 last. Each output term sums only the products whose index pairs lie inside both vectors. The terms at the two ends therefore have fewer products than the middle ones. A term of k products takes k accumulate cycles plus at least one presentation cycle. The maximum lengths and the element width are parameters. The accumulator is sized so that no term can overflow.

Top module: `vec_conv_engine`

## Requirements
- R1: An accepted start yields exactly m+n−1 output transfers. `res_last` is high on the final transfer and low on all others.
- R2: With element e stored at `wr_idx` = e−1 (0-based, a_1 at index 0), output term c_i equals the sum of a_j·b_k over j+k = i+1. Terms leave in descending i, so A=[1 2 3], B=[4 5] (a_3=1, b_2=4) gives 4, 13, 22, 15.
- R3: Only index pairs inside both vectors contribute, with no wrap-around. This covers the case where either length is 1.
- R4: Elements are two's complement and `res_data` is sign-extended to ACC_W = 2·DATA_W + ceil(log2(min(MAX_M, MAX_N))). No term overflows, even when every element is the most negative value.
- R5: `busy` rises in the cycle after an accepted start. It falls in the cycle after the last term is accepted, and `res_valid` is only high while `busy` is high.
- R6: A start pulse while `busy` is high is ignored, and the run in progress continues unchanged.
- R7: While `res_valid` is high and `res_ready` is low, `res_data`, `res_last` and `res_valid` hold their values.
- R8: Writes while `busy` is high are ignored. Both the current run and later runs use the data stored before the start.
- R9: A start with a length of 0, `len_a` above MAX_M or `len_b` above MAX_N is ignored, and `busy` stays low.
- R10: After reset, `busy` and `res_valid` are low and both stores hold zero.
- R11: `wr_sel` = 0 writes store A and `wr_sel` = 1 writes store B. Writes to indices at or beyond the store depth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Element write strobe |
| wr_sel | input | 1 | Store select: 0 = A, 1 = B |
| wr_idx | input | IW | 0-based element index (element e at e−1) |
| wr_data | input | DATA_W | Signed element value |
| len_a | input | LW_A | Length m, sampled on start |
| len_b | input | LW_B | Length n, sampled on start |
| start | input | 1 | Launch pulse |
| busy | output | 1 | Run in progress |
| res_valid | output | 1 | Output term available |
| res_ready | input | 1 | Consumer accepts the term |
| res_data | output | ACC_W | Signed output term |
| res_last | output | 1 | Marks term c_1 |

## Verification
The bench targets the edge terms of unequal-length runs, including lengths of 1 on either side. A sequencer with wrong index bounds would either drop products there or wrap in elements from outside the vector. All-minimum-value operands at full length probe the accumulator width. An accumulator that was too narrow would return a flipped sign. The bench issues starts and writes during a run, and invalid lengths while idle; a block that did not ignore them would restart, corrupt the stream or raise `busy`. A random ready pattern exposes outputs that change while stalled, and a last flag or handshake that drops or repeats a term.

// File: rtl/vconv_pkg.sv
package vconv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_OUT  = 2'd2
   } vconv_state_e;

   // index width that never collapses to zero bits
   function automatic int unsigned idx_bits(input int unsigned v);
      return (v <= 1) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/vconv_store.sv
module vconv_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned IW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] cell_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q[g] <= '0;
         end else if (wr_en && (wr_idx == IW'(g))) begin
            cell_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_idx == IW'(i)) rd_data = cell_q[i];
      end
   end

endmodule

// File: rtl/vconv_seq.sv
module vconv_seq
   import vconv_pkg::*;
#(
   parameter int unsigned MAX_M = 8,
   parameter int unsigned MAX_N = 8,
   parameter int unsigned IW    = 3,
   parameter int unsigned LW_A  = 4,
   parameter int unsigned LW_B  = 4,
   parameter int unsigned RW    = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [LW_A-1:0] len_a,
   input  logic [LW_B-1:0] len_b,
   input  logic            res_ready,
   output logic            busy,
   output logic            res_valid,
   output logic            res_last,
   output logic            mac_en,
   output logic            mac_first,
   output logic [IW-1:0]   idx_a,
   output logic [IW-1:0]   idx_b
);

   localparam int unsigned CW = RW + 1;

   vconv_state_e    state_q;
   logic [RW-1:0]   r_q;
   logic [IW-1:0]   p_q;
   logic [IW-1:0]   plo_q;
   logic [LW_A-1:0] m_q;
   logic [LW_B-1:0] n_q;
   logic            first_q;

   logic [CW-1:0]   sel_m, sel_n, r_nx, p_hi_nx, p_lo_nx;
   logic            lens_ok;

   assign lens_ok = (len_a != '0) && (CW'(len_a) <= CW'(MAX_M)) &&
                    (len_b != '0) && (CW'(len_b) <= CW'(MAX_N));

   // bounds of the next output term: p runs from p_hi down to p_lo
   always_comb begin
      sel_m   = (state_q == ST_IDLE) ? CW'(len_a) : CW'(m_q);
      sel_n   = (state_q == ST_IDLE) ? CW'(len_b) : CW'(n_q);
      r_nx    = (state_q == ST_IDLE) ? (sel_m + sel_n - CW'(2)) : (CW'(r_q) - CW'(1));
      p_hi_nx = (r_nx < (sel_m - CW'(1))) ? r_nx : (sel_m - CW'(1));
      p_lo_nx = (r_nx > (sel_n - CW'(1))) ? (r_nx - (sel_n - CW'(1))) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         r_q     <= '0;
         p_q     <= '0;
         plo_q   <= '0;
         m_q     <= '0;
         n_q     <= '0;
         first_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start && lens_ok) begin
                  m_q     <= len_a;
                  n_q     <= len_b;
                  r_q     <= RW'(r_nx);
                  p_q     <= IW'(p_hi_nx);
                  plo_q   <= IW'(p_lo_nx);
                  first_q <= 1'b1;
                  state_q <= ST_ACC;
               end
            end
            ST_ACC: begin
               first_q <= 1'b0;
               if (p_q == plo_q) begin
                  state_q <= ST_OUT;
               end else begin
                  p_q <= p_q - IW'(1);
               end
            end
            ST_OUT: begin
               if (res_ready) begin
                  if (r_q == '0) begin
                     state_q <= ST_IDLE;
                  end else begin
                     r_q     <= RW'(r_nx);
                     p_q     <= IW'(p_hi_nx);
                     plo_q   <= IW'(p_lo_nx);
                     first_q <= 1'b1;
                     state_q <= ST_ACC;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic [CW-1:0] q_full;
   assign q_full = CW'(r_q) - CW'(p_q);

   assign idx_a     = p_q;
   assign idx_b     = IW'(q_full);
   assign mac_en    = (state_q == ST_ACC);
   assign mac_first = first_q;
   assign busy      = (state_q != ST_IDLE);
   assign res_valid = (state_q == ST_OUT);
   assign res_last  = (state_q == ST_OUT) && (r_q == '0);

endmodule

// File: rtl/vconv_mac.sv
module vconv_mac #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ACC_W  = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              first,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic [ACC_W-1:0]  acc
);

   logic signed [2*DATA_W-1:0] prod;
   logic signed [ACC_W-1:0]    prod_ext;
   logic signed [ACC_W-1:0]    acc_q;

   assign prod     = $signed(op_a) * $signed(op_b);
   assign prod_ext = ACC_W'(prod);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (en) begin
         acc_q <= first ? prod_ext : (acc_q + prod_ext);
      end
   end

   assign acc = acc_q;

endmodule

// File: rtl/vec_conv_engine.sv
module vec_conv_engine
   import vconv_pkg::*;
#(
   parameter  int unsigned DATA_W = 8,
   parameter  int unsigned MAX_M  = 6,
   parameter  int unsigned MAX_N  = 5,
   localparam int unsigned MIN_L  = (MAX_M < MAX_N) ? MAX_M : MAX_N,
   localparam int unsigned ACC_W  = 2*DATA_W + ((MIN_L <= 1) ? 0 : $clog2(MIN_L)),
   localparam int unsigned IW     = idx_bits((MAX_M > MAX_N) ? MAX_M : MAX_N),
   localparam int unsigned LW_A   = idx_bits(MAX_M + 1),
   localparam int unsigned LW_B   = idx_bits(MAX_N + 1),
   localparam int unsigned RW     = idx_bits(MAX_M + MAX_N - 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [IW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LW_A-1:0]   len_a,
   input  logic [LW_B-1:0]   len_b,
   input  logic              start,
   output logic              busy,
   output logic              res_valid,
   input  logic              res_ready,
   output logic [ACC_W-1:0]  res_data,
   output logic              res_last
);

   if (DATA_W < 2 || MAX_M < 1 || MAX_N < 1) begin : g_bad_cfg
      $error("vec_conv_engine: DATA_W >= 2 and both maximum lengths >= 1 are required");
   end

   logic              wr_a, wr_b;
   logic              mac_en, mac_first;
   logic [IW-1:0]     idx_a, idx_b;
   logic [DATA_W-1:0] elem_a, elem_b;

   assign wr_a = wr_en && !busy && !wr_sel;
   assign wr_b = wr_en && !busy &&  wr_sel;

   vconv_store #(.DATA_W(DATA_W), .DEPTH(MAX_M), .IW(IW)) i_store_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_a),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (idx_a),
      .rd_data (elem_a)
   );

   vconv_store #(.DATA_W(DATA_W), .DEPTH(MAX_N), .IW(IW)) i_store_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_b),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (idx_b),
      .rd_data (elem_b)
   );

   vconv_seq #(
      .MAX_M (MAX_M),
      .MAX_N (MAX_N),
      .IW    (IW),
      .LW_A  (LW_A),
      .LW_B  (LW_B),
      .RW    (RW)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .len_a     (len_a),
      .len_b     (len_b),
      .res_ready (res_ready),
      .busy      (busy),
      .res_valid (res_valid),
      .res_last  (res_last),
      .mac_en    (mac_en),
      .mac_first (mac_first),
      .idx_a     (idx_a),
      .idx_b     (idx_b)
   );

   vconv_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mac_en),
      .first (mac_first),
      .op_a  (elem_a),
      .op_b  (elem_b),
      .acc   (res_data)
   );

endmodule

// File: rtl/vconv_checker.sv
module vconv_checker #(
   parameter int unsigned ACC_W = 19
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             res_valid,
   input logic             res_ready,
   input logic             res_last,
   input logic [ACC_W-1:0] res_data
);

   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_last))); // R7

   AST_VALID_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> busy); // R5

   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R5

   AST_LAST_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_ready && res_last) |=> !busy); // R1

   AST_RUN_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(res_valid && res_ready && res_last)) |=> busy); // R6

endmodule

bind vec_conv_engine vconv_checker #(.ACC_W(ACC_W)) i_vconv_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .res_valid (res_valid),
   .res_ready (res_ready),
   .res_last  (res_last),
   .res_data  (res_data)
);

// File: tb/test_vec_conv_engine.sv
module test_vec_conv_engine;

   localparam int unsigned DATA_W = 8;
   localparam int unsigned MAX_M  = 6;
   localparam int unsigned MAX_N  = 5;
   localparam int unsigned ACC_W  = 2*DATA_W + $clog2(MAX_N);
   localparam int unsigned IW     = $clog2(MAX_M);
   localparam int unsigned LW_A   = $clog2(MAX_M + 1);
   localparam int unsigned LW_B   = $clog2(MAX_N + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              wr_sel = 1'b0;
   logic [IW-1:0]     wr_idx = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [LW_A-1:0]   len_a = '0;
   logic [LW_B-1:0]   len_b = '0;
   logic              start = 1'b0;
   logic              busy, res_valid, res_last;
   logic              res_ready = 1'b0;
   logic [ACC_W-1:0]  res_data;

   always #5 clk = ~clk;

   vec_conv_engine #(.DATA_W(DATA_W), .MAX_M(MAX_M), .MAX_N(MAX_N)) i_vec_conv_engine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
      .wr_data(wr_data), .len_a(len_a), .len_b(len_b), .start(start), .busy(busy),
      .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_last(res_last)
   );

   int     n_checks = 0;
   int     n_fails  = 0;
   int     ma [MAX_M];
   int     mb [MAX_N];
   longint exp_q [$];
   longint got_q [$];
   logic   model_busy = 1'b0;
   int     ready_mode = 0;
   logic   hold_pend = 1'b0;
   logic [ACC_W-1:0] hold_data = '0;
   logic   hold_last = 1'b0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // behavioural reference, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic   rdy;
         logic   nb;
         longint e;
         nb = model_busy;
         check(busy === model_busy, "R5/R6/R9 busy", longint'(busy), longint'(model_busy));
         if (hold_pend)
            check(res_valid && res_data == hold_data && res_last == hold_last,
                  "R7 hold while stalled", longint'($signed(res_data)), longint'($signed(hold_data)));
         case (ready_mode)
            0:       rdy = 1'b1;
            1:       rdy = 1'($urandom % 2);
            default: rdy = ($urandom % 4) == 0;
         endcase
         res_ready = rdy;
         hold_pend = res_valid && !rdy;
         hold_data = res_data;
         hold_last = res_last;
         if (res_valid) begin
            if (!model_busy || exp_q.size() == 0) begin
               check(1'b0, "R1 unexpected term", longint'($signed(res_data)), 0);
            end else if (rdy) begin
               e = exp_q.pop_front();
               check(longint'($signed(res_data)) == e, "R2/R3/R4 term value",
                     longint'($signed(res_data)), e);
               check(res_last == (exp_q.size() == 0), "R1 last flag",
                     longint'(res_last), longint'(exp_q.size() == 0));
               got_q.push_back(longint'($signed(res_data)));
               if (exp_q.size() == 0) nb = 1'b0;
            end
         end
         // inputs that the next rising edge will see
         if (wr_en && !model_busy) begin
            if (!wr_sel && int'(wr_idx) < MAX_M) ma[wr_idx] = int'($signed(wr_data));
            if ( wr_sel && int'(wr_idx) < MAX_N) mb[wr_idx] = int'($signed(wr_data));
         end
         if (start && !model_busy && len_a != 0 && len_b != 0 &&
             int'(len_a) <= MAX_M && int'(len_b) <= MAX_N) begin
            for (int r = int'(len_a) + int'(len_b) - 2; r >= 0; r--) begin
               longint s;
               s = 0;
               for (int p = 0; p < int'(len_a); p++) begin
                  if (r - p >= 0 && r - p < int'(len_b)) s += longint'(ma[p]) * longint'(mb[r-p]);
               end
               exp_q.push_back(s);
            end
            nb = 1'b1;
         end
         model_busy = nb;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic put(input bit sel, input int idx, input int val);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_idx  = IW'(idx);
      wr_data = DATA_W'(val);
      tick();
      wr_en = 1'b0;
   endtask

   // values listed highest index first, as [x_len ... x_1]
   task automatic load(input bit sel, input int vals [$]);
      for (int k = 0; k < vals.size(); k++) put(sel, vals.size() - 1 - k, vals[k]);
   endtask

   task automatic pulse_start(input int m, input int n);
      len_a = LW_A'(m);
      len_b = LW_B'(n);
      start = 1'b1;
      tick();
      start = 1'b0;
   endtask

   task automatic finish_run(input int m, input int n);
      tick();
      while (busy || model_busy) tick();
      tick();
      check(exp_q.size() == 0 && got_q.size() == m + n - 1, "R1 term count",
            longint'(got_q.size()), longint'(m + n - 1));
   endtask

   task automatic run(input int m, input int n);
      got_q.delete();
      pulse_start(m, n);
      finish_run(m, n);
   endtask

   task automatic fill_random(input int lo, input int hi);
      for (int k = 0; k < MAX_M; k++) put(1'b0, k, lo + int'($urandom % (hi - lo + 1)));
      for (int k = 0; k < MAX_N; k++) put(1'b1, k, lo + int'($urandom % (hi - lo + 1)));
   endtask

   initial begin
      for (int k = 0; k < MAX_M; k++) ma[k] = 0;
      for (int k = 0; k < MAX_N; k++) mb[k] = 0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && res_valid == 1'b0, "R10 reset outputs", longint'({busy, res_valid}), 0);
      #1 rst_n = 1'b1;
      tick();

      // R10: stores start cleared, so a run yields zeros
      run(3, 2);

      // R2: worked example, written highest index first
      load(1'b0, '{1, 2, 3});
      load(1'b1, '{4, 5});
      run(3, 2);
      check(got_q.size() == 4 && got_q[0] == 4,  "R2 c4", got_q[0], 4);
      check(got_q.size() == 4 && got_q[1] == 13, "R2 c3", got_q[1], 13);
      check(got_q.size() == 4 && got_q[2] == 22, "R2 c2", got_q[2], 22);
      check(got_q.size() == 4 && got_q[3] == 15, "R2 c1", got_q[3], 15);

      // R11: out-of-depth B index is dropped; store A select checked by result
      put(1'b1, MAX_N, 99);
      run(3, 2);
      check(got_q.size() == 4 && got_q[3] == 15, "R11 store select", got_q[3], 15);

      // R3: edge terms with single-element operands and unequal lengths
      fill_random(-50, 50);
      run(MAX_M, 1);
      run(1, MAX_N);
      run(1, 1);
      run(2, MAX_N);
      run(MAX_M, MAX_N);

      // R4: extremes at full length
      fill_random(-128, -128);
      run(MAX_M, MAX_N);
      check(got_q.size() > 4 && got_q[4] == 81920, "R4 widest term", got_q[4], 81920);
      for (int k = 0; k < MAX_N; k++) put(1'b1, k, 127);
      run(MAX_M, MAX_N);

      // R7: stalls from the consumer
      fill_random(-128, 127);
      ready_mode = 1;
      run(MAX_M, MAX_N);
      ready_mode = 2;
      run(4, 3);

      // R6 and R8: start pulse and writes in the middle of a run
      ready_mode = 1;
      got_q.delete();
      pulse_start(5, 4);
      repeat (3) tick();
      pulse_start(2, 2);
      put(1'b0, 0, 77);
      put(1'b1, 1, -77);
      finish_run(5, 4);
      run(5, 4);
      ready_mode = 0;

      // R9: illegal lengths leave the block idle
      pulse_start(0, 3);
      repeat (2) tick();
      check(busy == 1'b0, "R9 zero length", longint'(busy), 0);
      pulse_start(MAX_M + 1, 2);
      repeat (2) tick();
      check(busy == 1'b0, "R9 length above max", longint'(busy), 0);
      pulse_start(3, 0);
      repeat (2) tick();
      check(busy == 1'b0, "R9 zero length b", longint'(busy), 0);

      // random sweep
      for (int t = 0; t < 40; t++) begin
         ready_mode = t % 3;
         fill_random(-128, 127);
         run(1 + int'($urandom % MAX_M), 1 + int'($urandom % MAX_N));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog R5: actual busy %0d expected run to complete", busy);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule